// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of one byte-wide parallel NOR flash lane. The host hands it one request at a time: an operation code, a 19-bit byte address and a data byte, qualified by a start strobe. The block then plays out the fixed unlock-and-command write sequence on the flash pins. It shapes every write strobe with a low width and a high width counted in system clocks.

After the last write the block polls the flash. It reads the target location repeatedly, with a fixed gap between reads, and watches data bit 7. While the embedded operation runs, that bit reads back as the complement of its final value. When the bit shows the expected value, the block raises `done_o` for one cycle. If a configurable number of polls pass without completion, it raises `timeout_o` instead. No ready pin is used.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and whenever the block is idle, chip enable, write enable and output enable (all active low) are high, and busy, done and timeout are low.
- R2: Operation code 0 (byte program) issues exactly four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (target address, program data).
- R3: Operation code 1 (sector erase) issues exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then 30h to the sector base. The sector base is the target address with bits 18:16 kept and bits 15:0 cleared.
- R4: Operation code 2 (chip erase) issues the same first five writes as R3, then (5555h, 10h).
- R5: Each write holds write enable low for exactly WE_LOW clocks, with chip enable low and output enable high. Consecutive writes are separated by exactly WE_HIGH clocks of write enable high. Write enable and output enable are never low together.
- R6: After the last write, the block performs one-clock reads (output enable low) separated by exactly POLL_GAP clocks. Completion is the first read whose flash data bit 7 equals the program data bit 7 for a program, or 1 for an erase.
- R7: On completion, `done_o` is high for exactly one clock, and `busy_o` is low in that same clock.
- R8: If POLL_MAX reads pass without completion, the block stops after the last of them. It pulses `timeout_o` for one clock, never asserts `done_o` for that operation, and returns to idle. A completion seen on the final allowed read counts as done.
- R9: A start strobe while busy is ignored. The running sequence is unchanged and no second operation follows it.
- R10: A start with the reserved operation code 3 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| addr_i | input | 19 | Target byte address |
| wdata_i | input | 8 | Byte to program |
| fa_o | output | 19 | Flash address |
| fdq_o | output | 8 | Data driven to flash during writes |
| fdq7_i | input | 1 | Flash data bit 7 read back during polling |
| fce_n_o | output | 1 | Flash chip enable, active low |
| fwe_n_o | output | 1 | Flash write enable, active low |
| foe_n_o | output | 1 | Flash output enable, active low |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle polling timeout pulse |

## Verification
The bench logs every write by the rising edge of write enable. It compares the address and data against the unlock table for each operation. A design with a swapped unlock address or a wrong final code fails the per-write comparison. A design that keeps the low address bits on a sector erase fails the same comparison.

The bench flash model returns the complement of bit 7 for a chosen number of reads and then the true value. It covers a program whose data bit 7 is 0, and a completion that arrives on the last allowed read. A design with inverted polarity, or one that checks the limit before the data, would report a timeout there or finish one read early.

A start pulse injected mid-sequence catches a design that relatches the request or queues a second operation. A reserved code catches a design that treats code 3 as an erase.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int FA_W = 19;
    localparam int DQ_W = 8;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLO,
        ST_WHI,
        ST_GAP,
        ST_READ
    } st_e;

    typedef struct packed {
        logic [FA_W-1:0] addr;
        logic [DQ_W-1:0] data;
    } bus_cyc_t;

    typedef struct packed {
        op_e             op;
        logic [FA_W-1:0] tgt;
        logic [DQ_W-1:0] wd;
    } req_t;

    localparam logic [FA_W-1:0] UNLK_A = 19'h05555;
    localparam logic [FA_W-1:0] UNLK_B = 19'h02AAA;

    // index of the final write of a sequence
    function automatic logic [IDX_W-1:0] last_idx(op_e op);
        return (op == OP_PROG) ? IDX_W'(3) : IDX_W'(5);
    endfunction

    // polled bit 7 value that signals completion
    function automatic logic done_bit(req_t r);
        return (r.op == OP_PROG) ? r.wd[DQ_W-1] : 1'b1;
    endfunction

    function automatic bus_cyc_t cmd_at(req_t r, logic [IDX_W-1:0] idx, int sect_w);
        bus_cyc_t        c;
        logic [FA_W-1:0] keep;
        keep = {FA_W{1'b1}} << (FA_W - sect_w);
        c = '{addr: UNLK_A, data: 8'hAA};
        if (r.op == OP_PROG) begin
            case (idx)
                3'd0:    c = '{addr: UNLK_A, data: 8'hAA};
                3'd1:    c = '{addr: UNLK_B, data: 8'h55};
                3'd2:    c = '{addr: UNLK_A, data: 8'hA0};
                default: c = '{addr: r.tgt,  data: r.wd};
            endcase
        end else begin
            case (idx)
                3'd0:    c = '{addr: UNLK_A, data: 8'hAA};
                3'd1:    c = '{addr: UNLK_B, data: 8'h55};
                3'd2:    c = '{addr: UNLK_A, data: 8'h80};
                3'd3:    c = '{addr: UNLK_A, data: 8'hAA};
                3'd4:    c = '{addr: UNLK_B, data: 8'h55};
                default: c = (r.op == OP_CHIP) ? '{addr: UNLK_A, data: 8'h10}
                                               : '{addr: r.tgt & keep, data: 8'h30};
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/fcs_phase_timer.sv
module fcs_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fcs_poll_ctr.sv
module fcs_poll_ctr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int PW = $clog2(LIMIT + 1);
    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + PW'(1);
        end
    end

    // the read in progress is the last one allowed
    assign at_limit = (cnt == PW'(LIMIT - 1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int SECT_W   = 3,
    parameter int WE_LOW   = 3,
    parameter int WE_HIGH  = 2,
    parameter int POLL_GAP = 4,
    parameter int POLL_MAX = 4000000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [FA_W-1:0] addr_i,
    input  logic [DQ_W-1:0] wdata_i,
    output logic [FA_W-1:0] fa_o,
    output logic [DQ_W-1:0] fdq_o,
    input  logic            fdq7_i,
    output logic            fce_n_o,
    output logic            fwe_n_o,
    output logic            foe_n_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            timeout_o
);
    localparam int MAXPH = (WE_LOW > WE_HIGH) ? ((WE_LOW > POLL_GAP) ? WE_LOW : POLL_GAP)
                                              : ((WE_HIGH > POLL_GAP) ? WE_HIGH : POLL_GAP);
    localparam int TW = $clog2(MAXPH + 1);

    st_e             st, st_nxt;
    req_t            req;
    logic [IDX_W-1:0] idx;
    logic            t_exp, t_load;
    logic [TW-1:0]   t_val;
    logic            poll_last, poll_inc;
    logic            hit;
    bus_cyc_t        cyc;

    assign hit = (fdq7_i == done_bit(req));

    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE: if (start_i && op_e'(op_i) != OP_RSVD) st_nxt = ST_WLO;
            ST_WLO:  if (t_exp) st_nxt = ST_WHI;
            ST_WHI:  if (t_exp) st_nxt = (idx == last_idx(req.op)) ? ST_GAP : ST_WLO;
            ST_GAP:  if (t_exp) st_nxt = ST_READ;
            ST_READ: st_nxt = (hit || poll_last) ? ST_IDLE : ST_GAP;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        t_load = (st_nxt != st);
        case (st_nxt)
            ST_WLO:  t_val = TW'(WE_LOW);
            ST_WHI:  t_val = TW'(WE_HIGH);
            ST_GAP:  t_val = TW'(POLL_GAP);
            default: t_val = TW'(1);
        endcase
    end

    assign poll_inc = (st == ST_READ) && (st_nxt == ST_GAP);

    fcs_phase_timer #(.W(TW)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    fcs_poll_ctr #(.LIMIT(POLL_MAX)) i_poll (
        .clk(clk), .rst(rst), .clr(st == ST_IDLE), .inc(poll_inc), .at_limit(poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            idx       <= '0;
            req       <= '{op: OP_PROG, tgt: '0, wd: '0};
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            st        <= st_nxt;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            if (st == ST_IDLE && st_nxt == ST_WLO) begin
                req <= '{op: op_e'(op_i), tgt: addr_i, wd: wdata_i};
                idx <= '0;
            end
            if (st == ST_WHI && st_nxt == ST_WLO) begin
                idx <= idx + IDX_W'(1);
            end
            if (st == ST_READ) begin
                if (hit)            done_o    <= 1'b1;
                else if (poll_last) timeout_o <= 1'b1;
            end
        end
    end

    assign cyc     = cmd_at(req, idx, SECT_W);
    assign fa_o    = (st == ST_GAP || st == ST_READ) ? req.tgt : cyc.addr;
    assign fdq_o   = cyc.data;
    assign fce_n_o = (st == ST_IDLE);
    assign fwe_n_o = (st != ST_WLO);
    assign foe_n_o = (st != ST_READ);
    assign busy_o  = (st != ST_IDLE);
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int WE_LOW = 3
) (
    input logic clk,
    input logic rst,
    input logic fce_n_o,
    input logic fwe_n_o,
    input logic foe_n_o,
    input logic busy_o,
    input logic done_o,
    input logic timeout_o
);
    int lo_run;

    always_ff @(posedge clk) begin
        if (rst)           lo_run <= 0;
        else if (!fwe_n_o) lo_run <= lo_run + 1;
        else               lo_run <= 0;
    end

    p_idle_rails_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (fce_n_o && fwe_n_o && foe_n_o));

    p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fwe_n_o) |-> (lo_run == WE_LOW));

    p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!fwe_n_o && !foe_n_o));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_end_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));

    p_timeout_single_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);
endmodule

bind flash_cmd_seq fcs_checker #(.WE_LOW(WE_LOW)) i_fcs_checker (
    .clk(clk), .rst(rst), .fce_n_o(fce_n_o), .fwe_n_o(fwe_n_o), .foe_n_o(foe_n_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
    localparam int WE_LOW = 3;
    localparam int WE_HIGH = 2;
    localparam int POLL_GAP = 2;
    localparam int POLL_MAX = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [18:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [18:0] fa_o;
    logic [7:0]  fdq_o;
    logic        fdq7_i = 1'b0;
    logic        fce_n_o, fwe_n_o, foe_n_o, busy_o, done_o, timeout_o;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_cmd_seq #(.SECT_W(3), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH),
                    .POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .fa_o(fa_o), .fdq_o(fdq_o), .fdq7_i(fdq7_i),
        .fce_n_o(fce_n_o), .fwe_n_o(fwe_n_o), .foe_n_o(foe_n_o),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    // vector fields: op[37:36] addr[35:17] data[16:9] ncomp[8:1] inject[0]
    localparam logic [37:0] VEC [0:5] = '{
        {2'd0, 19'h12345, 8'hC3, 8'd2,  1'b0},
        {2'd0, 19'h7FFFF, 8'h3C, 8'd0,  1'b0},
        {2'd1, 19'h5ABCD, 8'h00, 8'd3,  1'b1},
        {2'd2, 19'h00000, 8'h00, 8'd1,  1'b0},
        {2'd0, 19'h00001, 8'h80, 8'd10, 1'b0},
        {2'd1, 19'h7FFFF, 8'h00, 8'd5,  1'b0}
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [26:0] exp_cyc(int op, int i, logic [18:0] a, logic [7:0] d);
        if (op == 0) begin
            case (i)
                0: return {19'h05555, 8'hAA};
                1: return {19'h02AAA, 8'h55};
                2: return {19'h05555, 8'hA0};
                default: return {a, d};
            endcase
        end
        case (i)
            0: return {19'h05555, 8'hAA};
            1: return {19'h02AAA, 8'h55};
            2: return {19'h05555, 8'h80};
            3: return {19'h05555, 8'hAA};
            4: return {19'h02AAA, 8'h55};
            default: return (op == 2) ? {19'h05555, 8'h10} : {a[18:16], 16'h0000, 8'h30};
        endcase
    endfunction

    task automatic run_op(input int op, input logic [18:0] a, input logic [7:0] d,
                          input int ncomp, input bit inj);
        logic [26:0] log_w [0:7];
        int  nw = 0, lo = 0, hi = 0, reads = 0, gap = 0, ndone = 0, nto = 0;
        bit  prev_we = 1'b1;
        bit  expbit = (op == 0) ? d[7] : 1'b1;
        bit  exp_done = (ncomp < POLL_MAX);
        int  exp_nw = (op == 0) ? 4 : 6;
        string rq = (op == 0) ? "R2" : ((op == 1) ? "R3" : "R4");
        @(negedge clk);
        op_i = op[1:0]; addr_i = a; wdata_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (inj && cyc == 5) begin
                start_i = 1'b1; op_i = 2'd2; addr_i = 19'h11111;
            end else begin
                start_i = 1'b0;
            end
            if (!fwe_n_o) begin
                if (prev_we) begin
                    if (nw < 8) log_w[nw] = {fa_o, fdq_o};
                    if (nw > 0) chk(hi == WE_HIGH, "R5 we high gap", hi, WE_HIGH);
                    lo = 1;
                end else lo++;
                chk(!fce_n_o && foe_n_o, "R5 ce low oe high in write", {fce_n_o, foe_n_o}, 1);
            end else begin
                if (!prev_we) begin
                    chk(lo == WE_LOW, "R5 we low width", lo, WE_LOW);
                    nw++;
                    hi = 1;
                end else hi++;
            end
            prev_we = fwe_n_o;
            if (!foe_n_o) begin
                reads++;
                if (reads > 1) chk(gap == POLL_GAP, "R6 poll gap", gap, POLL_GAP);
                gap = 0;
                fdq7_i = (reads <= ncomp) ? ~expbit : expbit;
            end else if (reads > 0) gap++;
            if (done_o) begin
                ndone++;
                chk(!busy_o, "R7 busy low with done", busy_o, 0);
            end
            if (timeout_o) nto++;
            if (done_o || timeout_o) break;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(nw == exp_nw, {rq, " write count"}, nw, exp_nw);
        for (int i = 0; i < exp_nw && i < nw && i < 8; i++)
            chk(log_w[i] == exp_cyc(op, i, a, d), {rq, " write content"}, log_w[i], exp_cyc(op, i, a, d));
        chk(reads == (exp_done ? ncomp + 1 : POLL_MAX), "R6 read count", reads,
            exp_done ? ncomp + 1 : POLL_MAX);
        chk(ndone == (exp_done ? 1 : 0), "R8 done outcome", ndone, exp_done ? 1 : 0);
        chk(nto == (exp_done ? 0 : 1), "R8 timeout outcome", nto, exp_done ? 0 : 1);
        @(negedge clk);
        chk(!done_o && !timeout_o, "R7 pulse one cycle", {done_o, timeout_o}, 0);
        @(negedge clk);
        chk(!busy_o && fce_n_o, inj ? "R9 no queued op" : "R1 idle after op", busy_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fce_n_o && fwe_n_o && foe_n_o, "R1 rails after reset",
            {fce_n_o, fwe_n_o, foe_n_o}, 7);
        chk(!busy_o && !done_o && !timeout_o, "R1 status after reset",
            {busy_o, done_o, timeout_o}, 0);
        for (int v = 0; v < 6; v++)
            run_op(int'(VEC[v][37:36]), VEC[v][35:17], VEC[v][16:9],
                   int'(VEC[v][8:1]), VEC[v][0]);
        // R10: reserved code
        @(negedge clk);
        op_i = 2'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!busy_o && fwe_n_o && fce_n_o, "R10 reserved op ignored", busy_o, 0);
            @(negedge clk);
        end
        summary();
    end
endmodule